// File: doc/BRIEF.md
# Bidirectional token row scanner

This block is the logic core of a cascadable display row driver. A pulse on whichever cascade port is currently the input clears the scan chain and places one active token in the first stage. The token then moves one stage on every rising clock edge. When it leaves the last stage it appears for one cycle on the other cascade port, where the next device in the chain picks it up. After that the chain stays empty until the next pulse. The pads, level translation and high-voltage drivers sit outside this block. The block presents each cascade port as an input, an output and an output enable, and the row outputs as a level vector plus one common drive enable.

A direction input chooses which cascade port is the input. A scan-order input works with the direction input to decide whether the token moves from the lowest row towards the highest, or the other way round. A polarity input sets the level an active row drives. A high-impedance control releases every row regardless of where the token is.

Internally the token is held as a two-state machine, EMPTY and SCAN, together with a stage counter. The transitions are:
- INJECT: from EMPTY or SCAN to SCAN at stage 0 when the sampled input is high.
- ADVANCE: from SCAN to SCAN at the next stage.
- RETIRE: from SCAN at the last stage to EMPTY.
- HOLD: EMPTY stays in EMPTY while no pulse arrives.

Top module: `row_token_scanner`

## Requirements
- R1: The design has STAGES stages (default 40). Each stage drives one row. At most one row is active at any time, and exactly one is active while a token is inside.
- R2: While no input pulse is sampled, the token moves from stage k to stage k+1 on each rising clock edge.
- R3: An input sampled high on a rising edge places the token in stage 0 after that edge. This happens from the empty state and also in the middle of a scan. Holding the input high keeps the token in stage 0.
- R4: With dir=1, port A is the input and port B is the cascade output (port_b_oe=1, port_a_oe=0). With dir=0 the roles swap (port_a_oe=1, port_b_oe=0).
- R5: The port not selected as the output has its enable and its output at 0. The input of the port not selected as the input has no effect on the scan.
- R6: After the token leaves the last stage, every row is inactive until the next input pulse.
- R7: The output of the selected output port is 1 exactly while the token is in the last stage, which lasts one clock cycle.
- R8: Let reverse = (not dir) xor scan_order. When reverse=0, stage k drives row k. When reverse=1, stage k drives row STAGES-1-k.
- R9: An active row drives row_lvl = pol. Every inactive row drives row_lvl = not pol.
- R10: row_drv = not out_hiz, independent of the token position.
- R11: rst_n low empties the chain asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir | input | 1 | 1: port A is the input and port B the output; 0: the reverse |
| scan_order | input | 1 | Combined with dir to select the row scan order |
| pol | input | 1 | Level driven by the active row |
| out_hiz | input | 1 | 1 releases all rows (drive enable off) |
| port_a_i | input | 1 | Pad input of cascade port A |
| port_a_o | output | 1 | Pad output of cascade port A |
| port_a_oe | output | 1 | Pad drive enable of cascade port A |
| port_b_i | input | 1 | Pad input of cascade port B |
| port_b_o | output | 1 | Pad output of cascade port B |
| port_b_oe | output | 1 | Pad drive enable of cascade port B |
| row_lvl | output | STAGES | Level of each row output |
| row_drv | output | 1 | Common drive enable of all rows |

## Verification
The assertions assume the design is built with STAGES greater than one, so that the cascade pulse can never be followed at once by another token in the last stage. They also assume dir and scan_order are steady while a token is being tracked. The bench changes dir, scan_order, pol and out_hiz only while the chain is empty or between full scans. It drives the unused input port high only to show that this input is ignored. The bench sweeps all sixteen combinations of the four control inputs on an 8-stage instance, and computes the expected row vector from the stage index and the mirror rule.

// File: rtl/row_scan_pkg.sv
`timescale 1ns/1ps
package row_scan_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_SCAN  = 1'b1
    } scan_state_e;
endpackage

// File: rtl/scan_fsm.sv
`timescale 1ns/1ps
module scan_fsm
    import row_scan_pkg::*;
#(
    parameter int STAGES = 40,
    localparam int PW = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inject,
    output scan_state_e       state,
    output logic [PW-1:0]     pos
);
    localparam logic [PW-1:0] LAST_P = PW'(STAGES - 1);

    scan_state_e       state_nx;
    logic [PW-1:0]     pos_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            pos   <= '0;
        end else begin
            state <= state_nx;
            pos   <= pos_nx;
        end
    end

    // transitions: INJECT, ADVANCE, RETIRE, HOLD
    always_comb begin
        state_nx = state;
        pos_nx   = pos;
        unique case (state)
            ST_EMPTY: begin
                if (inject) begin
                    state_nx = ST_SCAN;
                    pos_nx   = '0;
                end
            end
            ST_SCAN: begin
                if (inject) begin
                    pos_nx = '0;
                end else if (pos == LAST_P) begin
                    state_nx = ST_EMPTY;
                    pos_nx   = '0;
                end else begin
                    pos_nx = pos + 1'b1;
                end
            end
            default: begin
                state_nx = ST_EMPTY;
                pos_nx   = '0;
            end
        endcase
    end

    AST_INJECT_STAGE0: assert property (@(posedge clk) disable iff (!rst_n)
        inject |=> (state == ST_SCAN && pos == '0)); // R3
    AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && !inject && pos != LAST_P) |=> (state == ST_SCAN && pos == $past(pos) + 1'b1)); // R2
    AST_RETIRE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && !inject && pos == LAST_P) |=> (state == ST_EMPTY)); // R6
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY && !inject) |=> (state == ST_EMPTY)); // R6
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST_P); // R1
endmodule

// File: rtl/row_map.sv
`timescale 1ns/1ps
module row_map #(
    parameter int STAGES = 40,
    localparam int PW = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [PW-1:0]     pos,
    input  logic              reverse,
    input  logic              pol,
    input  logic              hiz,
    output logic [STAGES-1:0] row_lvl,
    output logic              row_drv
);
    logic [STAGES-1:0] row_hit;

    for (genvar r = 0; r < STAGES; r++) begin : g_row
        localparam logic [PW-1:0] FWD_P = PW'(r);
        localparam logic [PW-1:0] BWD_P = PW'(STAGES - 1 - r);
        assign row_hit[r] = active && (reverse ? (pos == BWD_P) : (pos == FWD_P));
        assign row_lvl[r] = row_hit[r] ? pol : ~pol;
    end

    assign row_drv = ~hiz;

    AST_ONE_ROW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_hit)); // R1
    AST_ONE_ROW_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ($countones(row_hit) == 1)); // R1
endmodule

// File: rtl/cascade_port.sv
`timescale 1ns/1ps
module cascade_port (
    input  logic dir,
    input  logic a_i,
    input  logic b_i,
    input  logic last_tok,
    output logic inject,
    output logic a_o,
    output logic a_oe,
    output logic b_o,
    output logic b_oe
);
    always_comb begin
        inject = dir ? a_i : b_i;
        a_oe   = ~dir;
        b_oe   = dir;
        a_o    = last_tok & ~dir;
        b_o    = last_tok & dir;
    end
endmodule

// File: rtl/row_token_scanner.sv
`timescale 1ns/1ps
module row_token_scanner
    import row_scan_pkg::*;
#(
    parameter int STAGES = 40,
    localparam int PW = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir,
    input  logic              scan_order,
    input  logic              pol,
    input  logic              out_hiz,
    input  logic              port_a_i,
    output logic              port_a_o,
    output logic              port_a_oe,
    input  logic              port_b_i,
    output logic              port_b_o,
    output logic              port_b_oe,
    output logic [STAGES-1:0] row_lvl,
    output logic              row_drv
);
    localparam logic [PW-1:0] LAST_P = PW'(STAGES - 1);

    scan_state_e   state;
    logic [PW-1:0] pos;
    logic          inject;
    logic          last_tok;
    logic          reverse;

    assign last_tok = (state == ST_SCAN) && (pos == LAST_P);
    assign reverse  = ~dir ^ scan_order;

    cascade_port u_port (
        .dir      (dir),
        .a_i      (port_a_i),
        .b_i      (port_b_i),
        .last_tok (last_tok),
        .inject   (inject),
        .a_o      (port_a_o),
        .a_oe     (port_a_oe),
        .b_o      (port_b_o),
        .b_oe     (port_b_oe)
    );

    scan_fsm #(.STAGES(STAGES)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .inject (inject),
        .state  (state),
        .pos    (pos)
    );

    row_map #(.STAGES(STAGES)) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state == ST_SCAN),
        .pos     (pos),
        .reverse (reverse),
        .pol     (pol),
        .hiz     (out_hiz),
        .row_lvl (row_lvl),
        .row_drv (row_drv)
    );

    AST_CASCADE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (port_a_o || port_b_o) |=> !(port_a_o || port_b_o)); // R7
    AST_PORT_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({port_a_oe, port_b_oe}) == 1); // R4
endmodule

// File: tb/tb_row_token_scanner.sv
`timescale 1ns/1ps
module tb_row_token_scanner;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir = 1'b1, scan_order = 1'b0, pol = 1'b1, out_hiz = 1'b0;
    logic port_a_i = 1'b0, port_b_i = 1'b0;
    logic port_a_o, port_a_oe, port_b_o, port_b_oe, row_drv;
    logic [N-1:0] row_lvl;
    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    row_token_scanner #(.STAGES(N)) dut (
        .clk(clk), .rst_n(rst_n), .dir(dir), .scan_order(scan_order),
        .pol(pol), .out_hiz(out_hiz),
        .port_a_i(port_a_i), .port_a_o(port_a_o), .port_a_oe(port_a_oe),
        .port_b_i(port_b_i), .port_b_o(port_b_o), .port_b_oe(port_b_oe),
        .row_lvl(row_lvl), .row_drv(row_drv)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_rows(input int p, input bit valid, input bit d, input bit o, input bit pl);
        logic [N-1:0] v;
        bit rev;
        rev = (!d) ^ o;
        for (int r = 0; r < N; r++) begin
            int st;
            st = rev ? (N - 1 - r) : r;
            v[r] = (valid && st == p) ? pl : !pl;
        end
        return v;
    endfunction

    task automatic set_in(input bit v);
        if (dir) port_a_i = v; else port_b_i = v;
    endtask

    task automatic set_other(input bit v);
        if (dir) port_b_i = v; else port_a_i = v;
    endtask

    // called at a negedge; leaves the token in stage 0 at the next negedge
    task automatic pulse_in();
        set_in(1'b1);
        @(negedge clk);
        set_in(1'b0);
    endtask

    task automatic check_state(input int p, input bit valid, input string req);
        logic [N-1:0] er;
        bit cas, cas_exp, oth;
        er = exp_rows(p, valid, dir, scan_order, pol);
        chk(row_lvl == er, req, 32'(row_lvl), 32'(er));
        cas = dir ? port_b_o : port_a_o;
        oth = dir ? port_a_o : port_b_o;
        cas_exp = valid && (p == N - 1);
        chk(cas == cas_exp, "R7 cascade", 32'(cas), 32'(cas_exp));
        chk({port_a_oe, port_b_oe, oth} == {!dir, dir, 1'b0}, "R4 R5 port roles",
            32'({port_a_oe, port_b_oe, oth}), 32'({!dir, dir, 1'b0}));
        chk(row_drv == !out_hiz, "R10 drive enable", 32'(row_drv), 32'(!out_hiz));
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R11 reset state
        #1;
        check_state(0, 0, "R11 reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state(0, 0, "R6 idle after reset");

        // R1 R2 R8 R9 R10: sweep of all control combinations
        for (int c = 0; c < 16; c++) begin
            dir = c[0]; scan_order = c[1]; pol = c[2]; out_hiz = c[3];
            @(negedge clk);
            check_state(0, 0, "R6 empty before scan");
            pulse_in();
            for (int p = 0; p < N; p++) begin
                check_state(p, 1, "R1 R2 R8 R9 scan");
                if (p == 2) set_other(1'b1); // R5: ignored input
                @(negedge clk);
            end
            set_other(1'b0);
            check_state(0, 0, "R6 after exit");
            @(negedge clk);
            check_state(0, 0, "R6 stays empty");
        end

        // R3 override mid-scan, both directions
        for (int d = 0; d < 2; d++) begin
            dir = d[0]; scan_order = 1'b0; pol = 1'b1; out_hiz = 1'b0;
            @(negedge clk);
            pulse_in();
            for (int k = 0; k < 4; k++) @(negedge clk);
            check_state(4, 1, "R2 before override");
            pulse_in();
            check_state(0, 1, "R3 override");
            // R3 held input keeps stage 0
            set_in(1'b1);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check_state(0, 1, "R3 held");
            end
            set_in(1'b0);
            @(negedge clk);
            check_state(1, 1, "R2 resume");
            for (int k = 0; k < N; k++) @(negedge clk);
        end

        // R11 asynchronous reset mid-scan
        dir = 1'b1;
        @(negedge clk);
        pulse_in();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_state(0, 0, "R11 async clear");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state(0, 0, "R11 stays empty");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule